// File: doc/BRIEF.md
# Periodic Tick Down-Counter

The block is a register-mapped periodic timer built around a 24-bit counter that counts down and, once it has reached zero, takes its next value from a programmable reload register. With a reload value of N, the counter returns to zero every N+1 counting steps. Each 1-to-0 passage sets a sticky count flag. When interrupt enable is set, the same passage also raises a one-cycle tick interrupt pulse. Counting steps come either from every clock cycle or from a one-cycle external reference strobe, chosen by a control bit.

Software reaches three word registers over a simple single-cycle bus. Reads return data one cycle after the request. The control/status register drops its count flag as a side effect of being read. Writing any value to the current-value register forces the counter to zero and drops the flag. The counter is periodic only: one-shot use is obtained by rewriting the reload value and then writing the current-value register.

The counter is sequenced by three states:
- `ST_HALT` means counting is disabled and the count is frozen.
- `ST_LOAD` means the count is zero and the next step loads the reload value.
- `ST_DOWN` means the count is non-zero and each step decrements it.

The transitions are:
- **enable**: from `ST_HALT` to `ST_LOAD` or to `ST_DOWN`, depending on whether the count is zero.
- **disable**: from any state to `ST_HALT`.
- **load**: from `ST_LOAD` to `ST_DOWN`. The machine stays in `ST_LOAD` when the reload value is zero.
- **wrap**: from `ST_DOWN` to `ST_LOAD` on the step that takes the count from 1 to 0.
- **clear**: a current-value write, which goes to `ST_LOAD` when enabled and to `ST_HALT` otherwise.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers all read zero, and `tick_irq` is low.
- R2: The reload register stores only bits 23:0 of the write data. It reads back zero-extended, so writing 0xFFFFFFFF reads back 0x00FFFFFF.
- R3: In control/status (word index 0), bit 0 is counter enable, bit 1 is interrupt enable and bit 2 is step-source select. These bits read back as written. Bit 16 is the count flag. All other bits read zero.
- R4: With a reload value N of at least 1 and counting every clock, `tick_irq` pulses every N+1 cycles. Each pulse lasts exactly one cycle and follows the edge at which the count went from 1 to 0.
- R5: With interrupt enable at 0, `tick_irq` stays low, while counting and count-flag setting go on.
- R6: With counter enable at 0, the current value holds.
- R7: The count flag is set on each 1-to-0 step. A control/status read returns the flag and clears it. A wrap in the same cycle as the read leaves the flag set.
- R8: A write of any data to the current-value register (word index 2) sets the count to zero and clears the count flag.
- R9: A step taken with the count at zero loads the reload value and sets neither the flag nor `tick_irq`.
- R10: With source select at 0, the count changes only in cycles where `ref_strobe` is high. With source select at 1, it changes every enabled clock.
- R11: A current-value read returns the remaining count. The result of any read appears on `bus_rdata` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_en | input | 1 | Bus request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 control/status, 1 reload, 2 current value |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| ref_strobe | input | 1 | External reference step strobe, one cycle wide |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
A wrong state or count in this block first shows as a tick pulse that is early, late or missing, one cycle after the faulty step. It can also show as a current-value read that differs from the count expected from the number of steps since the last clear or load. Faults in the flag logic appear on the next control/status read, either as a flag that fails to survive a wrap or as one that fails to clear after a read or a current-value write. In reference-strobe mode the steps are driven one at a time, so a single missed or extra step is visible immediately at the next readback.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic [1:0] {
        A_CTRL    = 2'd0,
        A_RELOAD  = 2'd1,
        A_CURRENT = 2'd2,
        A_UNUSED  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_LOAD = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    localparam int BIT_EN  = 0;
    localparam int BIT_IE  = 1;
    localparam int BIT_SRC = 2;

    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              cnt_flag,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              cv_write,
    output logic              ctrl_read,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic              wr_ctrl, wr_reload, rd_any;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        wr_ctrl   = bus_en && bus_we && (reg_sel_e'(bus_addr) == A_CTRL);
        wr_reload = bus_en && bus_we && (reg_sel_e'(bus_addr) == A_RELOAD);
        cv_write  = bus_en && bus_we && (reg_sel_e'(bus_addr) == A_CURRENT);
        rd_any    = bus_en && !bus_we;
        ctrl_read = rd_any && (reg_sel_e'(bus_addr) == A_CTRL);
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_sel_e'(bus_addr))
            A_CTRL: begin
                rd_mux[BIT_EN]   = ctrl_q.en;
                rd_mux[BIT_IE]   = ctrl_q.ie;
                rd_mux[BIT_SRC]  = ctrl_q.src;
                rd_mux[FLAG_BIT] = cnt_flag;
            end
            A_RELOAD:  rd_mux = {{PAD_W{1'b0}}, reload_q};
            A_CURRENT: rd_mux = {{PAD_W{1'b0}}, cur_cnt};
            A_UNUSED:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            reload_q  <= '0;
            bus_rdata <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en  <= bus_wdata[BIT_EN];
                ctrl_q.ie  <= bus_wdata[BIT_IE];
                ctrl_q.src <= bus_wdata[BIT_SRC];
            end
            if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
            if (rd_any)    bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/tick_core.sv
module tick_core
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_q,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             cv_write,
    input  logic             ctrl_read,
    input  logic             ref_strobe,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             cnt_flag,
    output logic             tick_irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d, eff;
    logic [CNT_W-1:0] cnt_d;
    logic             step, wrap;

    // Next state and next count.
    always_comb begin
        step    = ctrl_q.en && (ctrl_q.src || ref_strobe);
        state_d = state_q;
        cnt_d   = cur_cnt;
        wrap    = 1'b0;
        eff     = state_q;
        if (state_q == ST_HALT && ctrl_q.en)
            eff = (cur_cnt == '0) ? ST_LOAD : ST_DOWN;
        if (cv_write) begin
            cnt_d   = '0;
            state_d = ctrl_q.en ? ST_LOAD : ST_HALT;
        end else if (!ctrl_q.en) begin
            state_d = ST_HALT;
        end else begin
            state_d = eff;
            unique case (eff)
                ST_LOAD: if (step) begin
                    cnt_d   = reload_q;
                    state_d = (reload_q == '0) ? ST_LOAD : ST_DOWN;
                end
                ST_DOWN: if (step) begin
                    cnt_d = cur_cnt - ONE;
                    if (cur_cnt == ONE) begin
                        wrap    = 1'b1;
                        state_d = ST_LOAD;
                    end
                end
                default: state_d = ST_HALT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Outputs: count, sticky flag, tick pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cnt  <= '0;
            cnt_flag <= 1'b0;
            tick_irq <= 1'b0;
        end else begin
            cur_cnt  <= cnt_d;
            tick_irq <= wrap && ctrl_q.ie;
            if (cv_write)       cnt_flag <= 1'b0;
            else if (wrap)      cnt_flag <= 1'b1;
            else if (ctrl_read) cnt_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_strobe,
    output logic              tick_irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q, cur_cnt;
    logic             cv_write, ctrl_read, cnt_flag;

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_cnt(cur_cnt),
        .cnt_flag(cnt_flag), .ctrl_q(ctrl_q), .reload_q(reload_q),
        .cv_write(cv_write), .ctrl_read(ctrl_read), .bus_rdata(bus_rdata)
    );

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .reload_q(reload_q),
        .cv_write(cv_write), .ctrl_read(ctrl_read), .ref_strobe(ref_strobe),
        .cur_cnt(cur_cnt), .cnt_flag(cnt_flag), .tick_irq(tick_irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic             tick_irq,
    input logic             ctl_en,
    input logic             ctl_ie,
    input logic [CNT_W-1:0] cur_cnt,
    input logic             cnt_flag
);
    logic cv_wr;
    assign cv_wr = bus_en && bus_we && (bus_addr == 2'd2);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);
    a_r4_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> (cur_cnt == '0) && cnt_flag);
    a_r5_ie_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ie |=> !tick_irq);
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cv_wr) |=> $stable(cur_cnt));
    a_r8_cv_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr |=> (cur_cnt == '0) && !cnt_flag);
    a_r9_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == '0) |=> !tick_irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .tick_irq(tick_irq), .ctl_en(ctrl_q.en),
    .ctl_ie(ctrl_q.ie), .cur_cnt(cur_cnt), .cnt_flag(cnt_flag)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0, ref_strobe = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ref_strobe(ref_strobe), .tick_irq(tick_irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } rd_item_t;

    rd_item_t    sb_q[$];
    int          n_tests = 0, n_fail = 0;
    logic [31:0] last_rd = '0;
    int          cyc = 0, irq_cnt = 0, last_irq = 0, interval = 0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares read results against the scoreboard.
    always @(posedge clk) begin
        if (bus_en && !bus_we) begin
            #1;
            if (sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                last_rd = bus_rdata;
                if (it.mask != 0) begin
                    n_tests++;
                    if ((bus_rdata & it.mask) != (it.exp & it.mask)) begin
                        n_fail++;
                        $display("FAIL %s: got %h expected %h", it.tag,
                                 bus_rdata & it.mask, it.exp & it.mask);
                    end
                end
            end
        end
    end

    // Tick pulse monitor.
    always @(posedge clk) begin
        #1;
        if (tick_irq) begin
            if (irq_cnt > 0) interval = cyc - last_irq;
            last_irq = cyc;
            irq_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [31:0] exp,
                            input logic [31:0] mask, input string tag);
        rd_item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic strobe();
        @(negedge clk); ref_strobe = 1;
        @(negedge clk); ref_strobe = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    localparam logic [31:0] ALL = 32'hFFFF_FFFF;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int held, c0;
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        bus_read(2'd0, 32'h0, ALL, "R1 ctrl");
        bus_read(2'd1, 32'h0, ALL, "R1 reload");
        bus_read(2'd2, 32'h0, ALL, "R1 current");
        check(tick_irq == 0 && irq_cnt == 0, "R1 irq", irq_cnt, 0);
        // R2 reload truncation
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, 32'h00FF_FFFF, ALL, "R2 reload width");
        // R4 period with reload 4, every clock
        bus_write(2'd1, 32'd4);
        bus_write(2'd2, 32'hDEAD_BEEF);
        bus_write(2'd0, 32'h7);
        bus_read(2'd0, 32'h7, 32'h0000_FFFF, "R3 ctrl bits");
        idle(40);
        check(interval == 5, "R4 period", interval, 5);
        check(irq_cnt >= 7 && irq_cnt <= 9, "R4 pulse count", irq_cnt, 8);
        // R6 hold when disabled
        bus_write(2'd0, 32'h4);
        bus_read(2'd2, 32'h0, 32'h0, "peek");
        held = last_rd;
        c0 = irq_cnt;
        idle(12);
        bus_read(2'd2, held, ALL, "R6 hold");
        check(irq_cnt == c0, "R6 no ticks while off", irq_cnt, c0);
        // R5 interrupt enable off: flag still sets, no irq
        bus_write(2'd1, 32'd9);
        bus_write(2'd2, 32'h0);
        bus_write(2'd0, 32'h5);
        idle(30);
        check(irq_cnt == c0, "R5 no irq", irq_cnt, c0);
        bus_write(2'd0, 32'h4);
        // R7 flag read-clear
        bus_read(2'd0, 32'h0001_0004, ALL, "R7 flag set");
        bus_read(2'd0, 32'h0000_0004, ALL, "R7 flag cleared by read");
        // R8 current-value write clears count and flag
        bus_write(2'd0, 32'h5);
        idle(30);
        bus_write(2'd0, 32'h4);
        bus_write(2'd2, 32'h1234_5678);
        bus_read(2'd2, 32'h0, ALL, "R8 count zero");
        bus_read(2'd0, 32'h4, ALL, "R8 flag cleared");
        // R10 strobe mode, R9 silent load, R11 remaining count
        bus_write(2'd1, 32'd3);
        bus_write(2'd0, 32'h3);
        c0 = irq_cnt;
        idle(8);
        bus_read(2'd2, 32'h0, ALL, "R10 no step without strobe");
        strobe();
        bus_read(2'd2, 32'd3, ALL, "R9 first step loads reload");
        check(irq_cnt == c0, "R9 no irq on load", irq_cnt, c0);
        bus_read(2'd0, 32'h3, ALL, "R9 no flag on load");
        strobe();
        bus_read(2'd2, 32'd2, ALL, "R11 remaining count");
        strobe();
        strobe();
        bus_read(2'd2, 32'd0, ALL, "R10 reached zero");
        check(irq_cnt == c0 + 1, "R4 strobe-mode tick", irq_cnt, c0 + 1);
        bus_read(2'd0, 32'h0001_0003, ALL, "R7 flag after wrap");
        idle(4);
        finish_run();
    end
endmodule